// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Datapath

This block is a 32-bit in-order datapath that runs a small instruction subset (register-register arithmetic and logic, word load, word store and branch-if-equal) through five one-cycle stages: fetch, decode with register read, execute, memory access and writeback. A register separates each pair of neighbouring stages. Once the pipe is full, one new instruction enters and one instruction retires on every clock.

There is no hazard hardware. The block has no forwarding, no interlock and no flush. Software must fill the three slots after a taken branch and the two slots after a load with independent work or no-ops. Every instruction that writes a register does so in stage 5, arithmetic included, so two writes never compete for the single write port. A taken branch is resolved in the memory stage and redirects fetch from there.

The instruction and data memories are small internal word arrays. They are filled through a preload port while reset is held. Debug outputs expose the fetch address and the register write being committed in the current cycle.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low on a clock edge, the next state has `dbg_pc` = 0 and `dbg_wb_en` = 0. Every stage register holds a no-op with all write enables cleared.
- R2: With no taken branch, the fetch address rises by 4 on each edge. The instruction fetched is the instruction-memory word at index `pc[MEM_AW+1:2]`. An instruction fetched in cycle s commits its register write (shown on `dbg_wb_*`) in cycle s+4.
- R3: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0]. Opcode 0x00 is the register-register class. Its functions are 0x20 add, 0x22 subtract (rs−rt), 0x24 and, 0x25 or, and 0x2A signed set-less-than (result 1 or 0). The result is written to rd.
- R4: Opcode 0x23 loads the data-memory word at (rs + sign-extended immediate) into rt. The word index is address bits [MEM_AW+1:2].
- R5: Opcode 0x2B writes the value of rt to the data word at (rs + sign-extended immediate) in the memory stage and writes no register.
- R6: Opcode 0x04 is taken when rs equals rt. The target is (branch address + 4) + (sign-extended immediate × 4). The target is fetched four cycles after the branch, so the three following instructions always complete. A branch that is not taken changes nothing, and a branch never writes a register.
- R7: An instruction one or two places after a load reads the old value of the load's destination. The instruction three places after reads the loaded value through the register-file bypass.
- R8: Register 0 reads as zero. A write aimed at it is dropped and is not shown on `dbg_wb_en`.
- R9: An undefined opcode, or the register-register class with an undefined function, acts as a no-op. All-zero words are no-ops.
- R10: A run of back-to-back register-register instructions commits one register write on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Preload write strobe for one memory word |
| ld_to_dmem | input | 1 | Preload target: 1 = data memory, 0 = instruction memory |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | 32 | Preload word value |
| dbg_pc | output | 32 | Address being fetched this cycle |
| dbg_wb_en | output | 1 | A register write commits this cycle |
| dbg_wb_reg | output | 5 | Destination register of that write |
| dbg_wb_data | output | 32 | Value being written |

## Verification
Two functions can fall in the same cycle: the writeback of a load and the decode-stage read of the same register by the instruction three places later. Programs put a load's destination into the sources of the three following instructions. The first two must commit the stale value and the third must commit the freshly loaded word. A second collision comes from a taken branch in the memory stage, which overrides the sequential increment in the very cycle the delay-slot instructions are still flowing. The program is judged on the fetch address, on the delay-slot writes arriving in consecutive cycles, and on the skipped instructions never writing. Expected values for the arithmetic sweep come from bench arithmetic on the preloaded operands.

// File: rtl/pipe5_pkg.sv
// Shared types and encodings for the five-stage datapath.
// Assumes a 32-bit word and a 32-entry register file.
package pipe5_pkg;

    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int IMM_W   = 16;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    // Control bundle produced in decode and consumed downstream
    typedef struct packed {
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    branch;
        logic    use_imm;
        alu_op_e alu_op;
        ridx_t   dest;
    } ctrl_t;

    typedef struct packed {
        word_t instr;
        word_t pc4;
    } ifid_t;

    typedef struct packed {
        ctrl_t ctrl;
        word_t pc4;
        word_t opa;
        word_t opb;
        word_t imm;
    } idex_t;

    typedef struct packed {
        logic  reg_write;
        logic  mem_read;
        logic  mem_write;
        logic  take;
        word_t target;
        word_t alu_y;
        word_t store_val;
        ridx_t dest;
    } exmem_t;

    typedef struct packed {
        logic  reg_write;
        logic  mem_read;
        word_t alu_y;
        word_t load_val;
        ridx_t dest;
    } memwb_t;

endpackage

// File: rtl/pipe5_decode.sv
// Instruction decoder: turns a fetched word into the control bundle,
// the sign-extended immediate and the two source register indices.
// Assumes undefined encodings must behave as no-ops, and register 0
// is never a real destination.
module pipe5_decode
    import pipe5_pkg::*;
(
    input  word_t instr,
    output ctrl_t ctrl,
    output word_t imm,
    output ridx_t rs,
    output ridx_t rt
);

    logic [5:0] opcode;
    logic [5:0] funct;
    ridx_t      rd;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign imm    = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    // Derive control from opcode and function fields
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctrl.dest = rd;
                case (funct)
                    FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_OR;  end
                    FN_SLT: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SLT; end
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.mem_read  = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.dest      = rt;
            end
            OP_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.use_imm   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
        if (ctrl.dest == '0) begin
            ctrl.reg_write = 1'b0;
        end
    end

endmodule

// File: rtl/pipe5_alu.sv
// Execute-stage arithmetic unit with a zero flag for branch compare.
// Assumes two's-complement operands; set-less-than is signed.
module pipe5_alu
    import pipe5_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_op_e op,
    output word_t   y,
    output logic    zero
);

    // Select the operation result
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/pipe5_regfile.sv
// Register file with two read ports and one write port. A write in the
// current cycle is bypassed to the read ports, so decode sees the value
// committed by writeback in the same cycle. Entry 0 reads as zero.
// Assumes the caller never asks for a write to entry 0 (it is dropped).
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t ra1,
    input  ridx_t ra2,
    output word_t rd1,
    output word_t rd2
);

    word_t regs [NREG];

    // Commit a write to any entry except zero
    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Read with same-cycle write bypass
    always_comb begin
        if (ra1 == '0)                 rd1 = '0;
        else if (we && waddr == ra1)   rd1 = wdata;
        else                           rd1 = regs[ra1];
        if (ra2 == '0)                 rd2 = '0;
        else if (we && waddr == ra2)   rd2 = wdata;
        else                           rd2 = regs[ra2];
    end

    // R7: a value written last cycle is what a later read returns
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(waddr) != '0 && ra1 == $past(waddr)
         && !(we && waddr == ra1)) |-> rd1 == $past(wdata));

endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order datapath: fetch, decode/register read, execute,
// memory, writeback. No forwarding, stalls or flushes; software fills
// the branch and load delay slots. Instruction and data memories are
// internal word arrays written through the preload port while reset
// is held. All register writes happen in stage 5.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int MEM_AW = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_to_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wb_en,
    output logic [RIDX_W-1:0] dbg_wb_reg,
    output logic [XLEN-1:0]   dbg_wb_data
);

    localparam int MEM_WORDS = 1 << MEM_AW;

    word_t  imem [MEM_WORDS];
    word_t  dmem [MEM_WORDS];

    word_t  pc_q, pc4_f, pc_next;
    ifid_t  ifid_q;
    idex_t  idex_q;
    exmem_t exmem_q;
    memwb_t memwb_q;

    ctrl_t  dec_ctrl;
    word_t  dec_imm, rf_rd1, rf_rd2, wb_val;
    ridx_t  dec_rs, dec_rt;
    word_t  alu_b, alu_y, br_target;
    logic   alu_zero;

    // ---------------- Fetch ----------------
    assign pc4_f   = pc_q + word_t'(4);
    assign pc_next = exmem_q.take ? exmem_q.target : pc4_f;

    // Program counter: sequential unless memory stage redirects
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction memory preload
    always_ff @(posedge clk) begin
        if (ld_en && !ld_to_dmem) imem[ld_addr] <= ld_data;
    end

    // IF/ID stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifid_q <= '0;
        end else begin
            ifid_q.instr <= imem[pc_q[MEM_AW+1:2]];
            ifid_q.pc4   <= pc4_f;
        end
    end

    // ---------------- Decode ----------------
    pipe5_decode u_decode (
        .instr (ifid_q.instr),
        .ctrl  (dec_ctrl),
        .imm   (dec_imm),
        .rs    (dec_rs),
        .rt    (dec_rt)
    );

    assign wb_val = memwb_q.mem_read ? memwb_q.load_val : memwb_q.alu_y;

    pipe5_regfile u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (memwb_q.reg_write),
        .waddr (memwb_q.dest),
        .wdata (wb_val),
        .ra1   (dec_rs),
        .ra2   (dec_rt),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2)
    );

    // ID/EX stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_q <= '0;
        end else begin
            idex_q.ctrl <= dec_ctrl;
            idex_q.pc4  <= ifid_q.pc4;
            idex_q.opa  <= rf_rd1;
            idex_q.opb  <= rf_rd2;
            idex_q.imm  <= dec_imm;
        end
    end

    // ---------------- Execute ----------------
    assign alu_b     = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.opb;
    assign br_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

    pipe5_alu u_alu (
        .a    (idex_q.opa),
        .b    (alu_b),
        .op   (idex_q.ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // EX/MEM stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exmem_q <= '0;
        end else begin
            exmem_q.reg_write <= idex_q.ctrl.reg_write;
            exmem_q.mem_read  <= idex_q.ctrl.mem_read;
            exmem_q.mem_write <= idex_q.ctrl.mem_write;
            exmem_q.take      <= idex_q.ctrl.branch && alu_zero;
            exmem_q.target    <= br_target;
            exmem_q.alu_y     <= alu_y;
            exmem_q.store_val <= idex_q.opb;
            exmem_q.dest      <= idex_q.ctrl.dest;
        end
    end

    // ---------------- Memory ----------------
    // Data memory: preload has priority over a store
    always_ff @(posedge clk) begin
        if (ld_en && ld_to_dmem) begin
            dmem[ld_addr] <= ld_data;
        end else if (exmem_q.mem_write) begin
            dmem[exmem_q.alu_y[MEM_AW+1:2]] <= exmem_q.store_val;
        end
    end

    // MEM/WB stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            memwb_q <= '0;
        end else begin
            memwb_q.reg_write <= exmem_q.reg_write;
            memwb_q.mem_read  <= exmem_q.mem_read;
            memwb_q.alu_y     <= exmem_q.alu_y;
            memwb_q.load_val  <= dmem[exmem_q.alu_y[MEM_AW+1:2]];
            memwb_q.dest      <= exmem_q.dest;
        end
    end

    // ---------------- Writeback / debug ----------------
    assign dbg_pc      = pc_q;
    assign dbg_wb_en   = memwb_q.reg_write;
    assign dbg_wb_reg  = memwb_q.dest;
    assign dbg_wb_data = wb_val;

    // R2: fetch addresses stay word aligned
    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);

    // R3: a register write leaving execute commits two cycles later
    a_r3_wb_two_after_ex: assert property (@(posedge clk) disable iff (!rst_n)
        idex_q.ctrl.reg_write |-> ##2 dbg_wb_en);

    // R5: a store in the memory stage is followed by no register write
    a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_q.mem_write |=> !memwb_q.reg_write);

    // R6: a taken branch in the memory stage steers the next fetch
    a_r6_branch_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_q.take |=> pc_q == $past(exmem_q.target));

endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
    import pipe5_pkg::*;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;
    localparam int MAXS  = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           ld_en = 1'b0;
    logic           ld_to_dmem = 1'b0;
    logic [AW-1:0]  ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [31:0]    dbg_pc;
    logic           dbg_wb_en;
    logic [4:0]     dbg_wb_reg;
    logic [31:0]    dbg_wb_data;

    pipe5_core #(.MEM_AW(AW)) u_pipe5_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_to_dmem(ld_to_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
        .dbg_wb_en(dbg_wb_en), .dbg_wb_reg(dbg_wb_reg), .dbg_wb_data(dbg_wb_data)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] prog [WORDS];
    logic [31:0] dm   [WORDS];
    logic        exp_en  [MAXS];
    logic [4:0]  exp_reg [MAXS];
    logic [31:0] exp_val [MAXS];
    string       exp_tag [MAXS];
    logic        pc_chk  [MAXS];
    logic [31:0] exp_pc  [MAXS];
    string       pc_tag  [MAXS];
    string       quiet_tag;

    function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < WORDS; i++) begin prog[i] = '0; dm[i] = '0; end
        for (int s = 0; s < MAXS; s++) begin
            exp_en[s] = 1'b0; exp_reg[s] = '0; exp_val[s] = '0; exp_tag[s] = "";
            pc_chk[s] = 1'b0; exp_pc[s] = '0; pc_tag[s] = "";
        end
    endtask

    task automatic want_wb(int s, int r, logic [31:0] v, string tag);
        exp_en[s] = 1'b1; exp_reg[s] = 5'(r); exp_val[s] = v; exp_tag[s] = tag;
    endtask

    task automatic want_pc(int s, logic [31:0] v, string tag);
        pc_chk[s] = 1'b1; exp_pc[s] = v; pc_tag[s] = tag;
    endtask

    // Preload under reset, release, then compare outputs at each negedge
    task automatic run(int nsamp);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < WORDS; i++) begin
            ld_en = 1'b1; ld_to_dmem = 1'b0; ld_addr = AW'(i); ld_data = prog[i];
            @(negedge clk);
        end
        for (int i = 0; i < WORDS; i++) begin
            ld_en = 1'b1; ld_to_dmem = 1'b1; ld_addr = AW'(i); ld_data = dm[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        check(dbg_pc == 32'h0, "R1", "pc in reset", dbg_pc, 32'h0);
        check(dbg_wb_en == 1'b0, "R1", "wb_en in reset", {31'b0, dbg_wb_en}, 32'h0);
        rst_n = 1'b1;
        for (int s = 1; s <= nsamp; s++) begin
            @(negedge clk);
            if (exp_en[s]) begin
                check(dbg_wb_en == 1'b1, exp_tag[s], $sformatf("wb_en s%0d", s),
                      {31'b0, dbg_wb_en}, 32'h1);
                check(dbg_wb_reg == exp_reg[s], exp_tag[s], $sformatf("wb_reg s%0d", s),
                      {27'b0, dbg_wb_reg}, {27'b0, exp_reg[s]});
                check(dbg_wb_data == exp_val[s], exp_tag[s], $sformatf("wb_data s%0d", s),
                      dbg_wb_data, exp_val[s]);
            end else begin
                check(dbg_wb_en == 1'b0, quiet_tag, $sformatf("no write s%0d", s),
                      {31'b0, dbg_wb_en}, 32'h0);
            end
            if (pc_chk[s]) begin
                check(dbg_pc == exp_pc[s], pc_tag[s], $sformatf("pc s%0d", s),
                      dbg_pc, exp_pc[s]);
            end
        end
    endtask

    function automatic logic [31:0] val_a(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'hFFFF_FFFF;
            default: return 32'(i) * 32'h9E37_79B9;
        endcase
    endfunction

    function automatic logic [31:0] val_b(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_0001;
            3: return 32'h0000_0001;
            default: return (32'(i) * 32'h85EB_CA6B) ^ 32'h0F0F_00FF;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Arithmetic sweep: R1 R2 R3 R4 R8 R9 R10
        for (int i = 0; i < 12; i++) begin
            logic [31:0] a, b, slt;
            a = val_a(i);
            b = val_b(i);
            slt = ($signed(a) < $signed(b)) ? 32'h1 : 32'h0;
            clear_all();
            quiet_tag = "R9";
            dm[0] = a; dm[1] = b;
            prog[0]  = i_ins(OP_LOAD, 0, 1, 0);
            prog[1]  = i_ins(OP_LOAD, 0, 2, 4);
            prog[5]  = r_ins(1, 2, 3, FN_ADD);
            prog[6]  = r_ins(1, 2, 4, FN_SUB);
            prog[7]  = r_ins(1, 2, 5, FN_AND);
            prog[8]  = r_ins(1, 2, 6, FN_OR);
            prog[9]  = r_ins(1, 2, 7, FN_SLT);
            prog[10] = r_ins(1, 2, 0, FN_ADD);
            prog[14] = r_ins(0, 1, 8, FN_OR);
            prog[15] = i_ins(6'h3F, 1, 3, 0);
            prog[16] = r_ins(1, 2, 9, 6'h3F);
            prog[17] = r_ins(0, 0, 10, FN_ADD);
            want_wb(4, 1, a, "R4");
            want_wb(5, 2, b, "R4");
            want_wb(9, 3, a + b, "R3");
            want_wb(10, 4, a - b, "R10");
            want_wb(11, 5, a & b, "R10");
            want_wb(12, 6, a | b, "R10");
            want_wb(13, 7, slt, "R3");
            want_wb(18, 8, a, "R8");
            want_wb(21, 10, 32'h0, "R8");
            for (int s = 1; s <= 22; s++) want_pc(s, 32'(4 * s), "R2");
            run(22);
        end

        // Load/store and load delay: R4 R5 R7
        clear_all();
        quiet_tag = "R5";
        dm[2] = 32'h1111_0000;
        dm[4] = 32'd32;
        dm[5] = 32'hCAFE_0001;
        dm[7] = 32'h2222_0000;
        prog[0]  = i_ins(OP_LOAD, 0, 9, 8);
        prog[1]  = i_ins(OP_LOAD, 0, 12, 16);
        prog[2]  = i_ins(OP_LOAD, 0, 13, 20);
        prog[5]  = i_ins(OP_STORE, 12, 13, -8);
        prog[6]  = i_ins(OP_LOAD, 12, 9, -4);
        prog[7]  = r_ins(9, 0, 14, FN_OR);
        prog[8]  = r_ins(9, 0, 15, FN_OR);
        prog[9]  = r_ins(9, 0, 16, FN_OR);
        prog[10] = i_ins(OP_LOAD, 0, 17, 24);
        want_wb(4, 9, 32'h1111_0000, "R4");
        want_wb(5, 12, 32'd32, "R4");
        want_wb(6, 13, 32'hCAFE_0001, "R4");
        want_wb(10, 9, 32'h2222_0000, "R4");
        want_wb(11, 14, 32'h1111_0000, "R7");
        want_wb(12, 15, 32'h1111_0000, "R7");
        want_wb(13, 16, 32'h2222_0000, "R7");
        want_wb(14, 17, 32'hCAFE_0001, "R5");
        for (int s = 1; s <= 16; s++) want_pc(s, 32'(4 * s), "R2");
        run(16);

        // Branches taken forward, not taken, taken backward: R6
        clear_all();
        quiet_tag = "R6";
        dm[0] = 32'd5; dm[1] = 32'd5; dm[2] = 32'd7;
        prog[0]  = i_ins(OP_LOAD, 0, 1, 0);
        prog[1]  = i_ins(OP_LOAD, 0, 2, 4);
        prog[2]  = i_ins(OP_LOAD, 0, 3, 8);
        prog[5]  = i_ins(OP_BEQ, 1, 2, 14);
        prog[6]  = r_ins(1, 0, 4, FN_OR);
        prog[7]  = r_ins(2, 0, 5, FN_OR);
        prog[8]  = r_ins(3, 0, 6, FN_OR);
        prog[9]  = r_ins(1, 0, 7, FN_OR);
        prog[12] = r_ins(2, 0, 10, FN_OR);
        prog[20] = r_ins(3, 0, 8, FN_OR);
        prog[21] = i_ins(OP_BEQ, 1, 3, 5);
        prog[22] = r_ins(1, 0, 9, FN_OR);
        prog[23] = i_ins(OP_BEQ, 0, 0, -12);
        want_wb(4, 1, 32'd5, "R4");
        want_wb(5, 2, 32'd5, "R4");
        want_wb(6, 3, 32'd7, "R4");
        want_wb(10, 4, 32'd5, "R6");
        want_wb(11, 5, 32'd5, "R6");
        want_wb(12, 6, 32'd7, "R6");
        want_wb(13, 8, 32'd7, "R6");
        want_wb(15, 9, 32'd5, "R6");
        want_wb(20, 10, 32'd5, "R6");
        for (int s = 1; s <= 8; s++)   want_pc(s, 32'(4 * s), "R2");
        for (int s = 9; s <= 15; s++)  want_pc(s, 32'(80 + 4 * (s - 9)), "R6");
        for (int s = 16; s <= 21; s++) want_pc(s, 32'(48 + 4 * (s - 16)), "R6");
        run(21);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule